// File: doc/BRIEF.md
# Sixteen-Pin Bidirectional Port with Pull-ups and Change Listeners

This block is one general-purpose I/O port. Software programs it over a simple register bus. A 32-bit control word holds two bits per pin, one to enable the output and one to enable the pull-up. A 16-bit data word holds the value the CPU drives. A peripheral next to the port can also drive any pin through its own enable and value vectors. The level on each pin is a wired-OR of three sources: the CPU drive, the peripheral drive, and the pull-up on a pin that neither of them drives. A read of the data address returns these resolved levels, not the value that was stored.

Several listener slots watch the port. Each slot has its own 16-bit watch mask. Whenever a bus write to the control or data word changes the resolved level of a pin that the slot watches, the slot raises a one-cycle strobe. To build two ports, instantiate the block twice.

Top module: `gpio_bank`

## Requirements
- R1: For every pin n, control bit 2n enables CPU drive. While it is set, the pin carries data bit n.
- R2: For every pin n, control bit 2n+1 enables the pull-up. It makes the pin read 1 only when neither the CPU nor the peripheral drives it.
- R3: A pin whose `per_oe` bit is set carries the matching `per_out` bit.
- R4: The three sources combine by OR. A driver that outputs 0 does not mask another driver that outputs 1. A pin driven to 0 by either side ignores its pull-up.
- R5: A read of the data word (address 1) returns the resolved pin levels in bits 15:0 and zeros above them. It never returns the stored CPU data value.
- R6: Size codes are 0 for byte, 1 for 16-bit and 2 for 32-bit. The control word (address 0) accepts only 32-bit writes. The data word and the masks (address 2+i for slot i) accept only 16-bit writes. A write of any other size to one of these addresses leaves every register unchanged, and `bus_err` is high in the cycle after that write.
- R7: After an accepted write to the control or data word, `chg_pulse[i]` is high for exactly the next cycle if slot i's mask shares any bit with the XOR of the pin levels before and after the write.
- R8: A write that leaves all pin levels unchanged produces no strobe, even if it changes the stored register contents.
- R9: Each slot is gated by its own mask, independently of the other slots. A change that lies wholly outside a slot's mask leaves that slot silent.
- R10: Reset clears the control word, the data word and all masks. The pins then resolve from the peripheral inputs alone, and `bus_err` and all strobes are low.
- R11: A change on the peripheral inputs with no register write never produces a strobe.
- R12: A write to a mask register produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Register address: 0 control, 1 data, 2+i mask of slot i |
| bus_size | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| bus_err | output | 1 | High for one cycle after a write of the wrong size |
| per_oe | input | 16 | Peripheral output enables, one per pin |
| per_out | input | 16 | Peripheral drive values, one per pin |
| pin_level | output | 16 | Resolved pin levels |
| chg_pulse | output | 4 | One-cycle change strobe per listener slot |

## Verification
Register contents, `pin_level` and `bus_rdata` take their new value in the same cycle as the clock edge that accepts a write. The strobes and `bus_err` come one cycle later, because each passes through one register stage fed by that edge. The bench presents each write before a rising edge and samples on the falling edge that follows it. At that point the new levels, the read-back data and the strobe or error for that single write are all valid together. For checks that no strobe appears, the bench holds the peripheral inputs for several cycles with no write and samples `chg_pulse` on every falling edge in that window.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2
  } acc_size_e;

  localparam int CTRL_ADDR = 0;
  localparam int DATA_ADDR = 1;
  localparam int MASK_BASE = 2;

endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int PINS      = 16,
  parameter int ADDR_W    = 4,
  parameter int LISTENERS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [1:0]            size_i,
  input  logic [31:0]           wdata_i,
  output logic [2*PINS-1:0]     ctrl_q_o,
  output logic [PINS-1:0]       data_q_o,
  output logic [2*PINS-1:0]     ctrl_d_o,
  output logic [PINS-1:0]       data_d_o,
  output logic                  lvl_wr_o,
  output logic [LISTENERS-1:0]  mask_we_o,
  output logic                  bus_err_o
);

  localparam int CTRL_W = 2 * PINS;

  acc_size_e         sz;
  logic              hit_ctrl, hit_data, hit_mask;
  logic              ctrl_en, data_en, err_d, err_q;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [PINS-1:0]   data_q, data_d;

  assign sz = acc_size_e'(size_i);

  // next-state and decode
  always_comb begin
    hit_ctrl  = (addr_i == ADDR_W'(CTRL_ADDR));
    hit_data  = (addr_i == ADDR_W'(DATA_ADDR));
    hit_mask  = 1'b0;
    mask_we_o = '0;
    for (int i = 0; i < LISTENERS; i++) begin
      if (addr_i == ADDR_W'(MASK_BASE + i)) begin
        hit_mask     = 1'b1;
        mask_we_o[i] = wr_i && (sz == ACC_HALF);
      end
    end
    ctrl_en = wr_i && hit_ctrl && (sz == ACC_WORD);
    data_en = wr_i && hit_data && (sz == ACC_HALF);
    err_d   = wr_i && ((hit_ctrl && (sz != ACC_WORD)) ||
                       ((hit_data || hit_mask) && (sz != ACC_HALF)));
    ctrl_d  = ctrl_en ? wdata_i[CTRL_W-1:0] : ctrl_q;
    data_d  = data_en ? wdata_i[PINS-1:0]   : data_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (data_en) data_q <= data_d;
      err_q <= err_d;
    end
  end

  assign ctrl_q_o  = ctrl_q;
  assign data_q_o  = data_q;
  assign ctrl_d_o  = ctrl_d;
  assign data_d_o  = data_d;
  assign lvl_wr_o  = ctrl_en || data_en;
  assign bus_err_o = err_q;

  AST_CTRL_BAD_SIZE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && hit_ctrl && (sz != ACC_WORD)) |=> $stable(ctrl_q))
    else $error("control word changed on a wrong-size write"); // R6
  AST_DATA_BAD_SIZE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && hit_data && (sz != ACC_HALF)) |=> $stable(data_q))
    else $error("data word changed on a wrong-size write"); // R6
  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(wr_i))
    else $error("bus error raised without a write"); // R6

endmodule

// File: rtl/gpio_bank_resolve.sv
module gpio_bank_resolve #(
  parameter int PINS = 16
) (
  input  logic [2*PINS-1:0] ctrl_i,
  input  logic [PINS-1:0]   data_i,
  input  logic [PINS-1:0]   per_oe_i,
  input  logic [PINS-1:0]   per_out_i,
  output logic [PINS-1:0]   level_o
);

  logic [PINS-1:0] cpu_oe, pull_en;

  // de-interleave: even bit enables drive, odd bit enables pull-up
  for (genvar n = 0; n < PINS; n++) begin : g_split
    assign cpu_oe[n]  = ctrl_i[2*n];
    assign pull_en[n] = ctrl_i[2*n+1];
  end

  assign level_o = (cpu_oe & data_i) |
                   (per_oe_i & per_out_i) |
                   (~(cpu_oe | per_oe_i) & pull_en);

endmodule

// File: rtl/gpio_bank_listener.sv
module gpio_bank_listener #(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_we_i,
  input  logic [PINS-1:0] mask_wdata_i,
  input  logic            lvl_wr_i,
  input  logic [PINS-1:0] changes_i,
  output logic [PINS-1:0] mask_o,
  output logic            pulse_o
);

  logic [PINS-1:0] mask_q, mask_d;
  logic            pulse_q, pulse_d;

  always_comb begin
    mask_d  = mask_we_i ? mask_wdata_i : mask_q;
    pulse_d = lvl_wr_i && (|(mask_q & changes_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_d;
      pulse_q <= pulse_d;
    end
  end

  assign mask_o  = mask_q;
  assign pulse_o = pulse_q;

  AST_PULSE_AFTER_LEVEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(lvl_wr_i))
    else $error("strobe without a control or data write"); // R11
  AST_MASK_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we_i |=> !pulse_q)
    else $error("strobe after a mask write"); // R12

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int PINS      = 16,
  parameter int ADDR_W    = 4,
  parameter int LISTENERS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [1:0]           bus_size,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_err,
  input  logic [PINS-1:0]      per_oe,
  input  logic [PINS-1:0]      per_out,
  output logic [PINS-1:0]      pin_level,
  output logic [LISTENERS-1:0] chg_pulse
);

  localparam int CTRL_W = 2 * PINS;

  logic [1:0]                      rst_sync;
  logic                            rst_s;
  logic [CTRL_W-1:0]               ctrl_q, ctrl_d;
  logic [PINS-1:0]                 data_q, data_d;
  logic [PINS-1:0]                 lvl_next, changes;
  logic                            lvl_wr;
  logic [LISTENERS-1:0]            mask_we;
  logic [LISTENERS-1:0][PINS-1:0]  masks;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  gpio_bank_regs #(.PINS(PINS), .ADDR_W(ADDR_W), .LISTENERS(LISTENERS)) regs_i (
    .clk(clk), .rst_n(rst_s), .wr_i(bus_wr), .addr_i(bus_addr), .size_i(bus_size),
    .wdata_i(bus_wdata), .ctrl_q_o(ctrl_q), .data_q_o(data_q), .ctrl_d_o(ctrl_d),
    .data_d_o(data_d), .lvl_wr_o(lvl_wr), .mask_we_o(mask_we), .bus_err_o(bus_err)
  );

  gpio_bank_resolve #(.PINS(PINS)) cur_i (
    .ctrl_i(ctrl_q), .data_i(data_q), .per_oe_i(per_oe), .per_out_i(per_out),
    .level_o(pin_level)
  );

  gpio_bank_resolve #(.PINS(PINS)) nxt_i (
    .ctrl_i(ctrl_d), .data_i(data_d), .per_oe_i(per_oe), .per_out_i(per_out),
    .level_o(lvl_next)
  );

  assign changes = pin_level ^ lvl_next;

  for (genvar i = 0; i < LISTENERS; i++) begin : g_slot
    gpio_bank_listener #(.PINS(PINS)) slot_i (
      .clk(clk), .rst_n(rst_s), .mask_we_i(mask_we[i]),
      .mask_wdata_i(bus_wdata[PINS-1:0]), .lvl_wr_i(lvl_wr),
      .changes_i(changes), .mask_o(masks[i]), .pulse_o(chg_pulse[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(CTRL_ADDR)) bus_rdata = 32'(ctrl_q);
    if (bus_addr == ADDR_W'(DATA_ADDR)) bus_rdata = 32'(pin_level);
    for (int i = 0; i < LISTENERS; i++) begin
      if (bus_addr == ADDR_W'(MASK_BASE + i)) bus_rdata = 32'(masks[i]);
    end
  end

  AST_SAME_LEVEL_QUIET: assert property (@(posedge clk) disable iff (!rst_s)
    (lvl_wr && (changes == '0)) |=> (chg_pulse == '0))
    else $error("strobe on a write that changed no pin"); // R8

endmodule

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb_top;

  typedef struct packed {
    logic [3:0]  addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [15:0] oe;
    logic [15:0] out;
    logic [15:0] lvl;
    logic [3:0]  pulse;
    logic        err;
  } vec_t;

  // masks in force: slot0 000F, slot1 00F0, slot2 FF00, slot3 FFFF
  localparam vec_t VECS [12] = '{
    '{4'd1, 2'd1, 32'h0000_00FF, 16'h0000, 16'h0000, 16'h0000, 4'b0000, 1'b0},
    '{4'd0, 2'd2, 32'h0000_0055, 16'h0000, 16'h0000, 16'h000F, 4'b1001, 1'b0},
    '{4'd0, 2'd2, 32'h00AA_0055, 16'h0000, 16'h0000, 16'h0F0F, 4'b1100, 1'b0},
    '{4'd1, 2'd1, 32'h0000_00FF, 16'h0100, 16'h0000, 16'h0E0F, 4'b0000, 1'b0},
    '{4'd1, 2'd1, 32'h0000_0000, 16'h0100, 16'h0100, 16'h0F00, 4'b1001, 1'b0},
    '{4'd0, 2'd2, 32'h00AA_0500, 16'h0030, 16'h0020, 16'h0F20, 4'b0000, 1'b0},
    '{4'd1, 2'd2, 32'h0000_FFFF, 16'h0030, 16'h0020, 16'h0F20, 4'b0000, 1'b1},
    '{4'd1, 2'd1, 32'h0000_FFFF, 16'h0030, 16'h0020, 16'h0F30, 4'b1010, 1'b0},
    '{4'd0, 2'd1, 32'h0000_0000, 16'h0030, 16'h0020, 16'h0F30, 4'b0000, 1'b1},
    '{4'd0, 2'd2, 32'h0000_0000, 16'h0000, 16'h0000, 16'h0000, 4'b1110, 1'b0},
    '{4'd0, 2'd2, 32'hFFFF_FFFF, 16'h0000, 16'h0000, 16'hFFFF, 4'b1111, 1'b0},
    '{4'd0, 2'd2, 32'hAAAA_AAAA, 16'h0000, 16'h0000, 16'hFFFF, 4'b0000, 1'b0}
  };
  localparam string VEC_REQ [12] = '{
    "R5 R8", "R1 R7 R9", "R2 R9", "R4 R8", "R3 R7", "R4 R8",
    "R6", "R7 R9", "R6", "R7 R9", "R1 R7", "R2 R8"
  };

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [15:0] per_oe, per_out, pin_level;
  logic [3:0]  chg_pulse;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;

  gpio_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .per_oe(per_oe), .per_out(per_out),
    .pin_level(pin_level), .chg_pulse(chg_pulse)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one write, return on the falling edge after the accepting edge
  task automatic bus_write(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a;
    #0.5;
    check(req, bus_rdata, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    bus_wr = 1'b0; bus_addr = '0; bus_size = '0; bus_wdata = '0;
    per_oe = '0; per_out = '0;
    do_reset();

    // R10 reset state
    check("R10 level", 32'(pin_level), 32'h0);
    check("R10 pulse", 32'(chg_pulse), 32'h0);
    check("R10 err", 32'(bus_err), 32'h0);
    read_chk("R10 ctrl", 4'd0, 32'h0);
    read_chk("R10 mask", 4'd2, 32'h0);

    // program masks; R12 no strobe after a mask write
    bus_write(4'd2, 2'd1, 32'h0000_000F); check("R12 pulse", 32'(chg_pulse), 32'h0);
    bus_write(4'd3, 2'd1, 32'h0000_00F0); check("R12 pulse", 32'(chg_pulse), 32'h0);
    bus_write(4'd4, 2'd1, 32'h0000_FF00); check("R12 pulse", 32'(chg_pulse), 32'h0);
    bus_write(4'd5, 2'd1, 32'h0000_FFFF); check("R12 pulse", 32'(chg_pulse), 32'h0);
    read_chk("R6 mask readback", 4'd4, 32'h0000_FF00);

    // vector table
    for (int k = 0; k < 12; k++) begin
      per_oe  = VECS[k].oe;
      per_out = VECS[k].out;
      bus_write(VECS[k].addr, VECS[k].size, VECS[k].wdata);
      check({VEC_REQ[k], " level"}, 32'(pin_level), 32'(VECS[k].lvl));
      check({VEC_REQ[k], " pulse"}, 32'(chg_pulse), 32'(VECS[k].pulse));
      check({VEC_REQ[k], " err"},   32'(bus_err),   32'(VECS[k].err));
      read_chk("R5 data read", 4'd1, 32'(VECS[k].lvl));
    end

    // R5: stored data cleared, pins held by pull-ups, read shows levels
    bus_write(4'd1, 2'd1, 32'h0000_0000);
    check("R5 level", 32'(pin_level), 32'h0000_FFFF);
    check("R8 pulse", 32'(chg_pulse), 32'h0);
    read_chk("R5 data read", 4'd1, 32'h0000_FFFF);

    // R11: peripheral takes every pin low with no write
    @(negedge clk);
    per_oe = 16'hFFFF; per_out = 16'h0000;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R11 pulse", 32'(chg_pulse), 32'h0);
    end
    check("R4 level", 32'(pin_level), 32'h0);

    // R6: wrong-size mask write ignored
    bus_write(4'd2, 2'd2, 32'h0000_1234);
    check("R6 err", 32'(bus_err), 32'h1);
    read_chk("R6 mask held", 4'd2, 32'h0000_000F);
    bus_write(4'd2, 2'd0, 32'h0000_0055);
    check("R6 err byte", 32'(bus_err), 32'h1);
    read_chk("R6 mask held", 4'd2, 32'h0000_000F);
    @(negedge clk);
    check("R6 err one cycle", 32'(bus_err), 32'h0);

    // R10: reset again mid-run
    per_oe = 16'h0000;
    do_reset();
    check("R10 level", 32'(pin_level), 32'h0);
    read_chk("R10 ctrl", 4'd0, 32'h0);
    read_chk("R10 mask", 4'd5, 32'h0);
    check("R10 pulse", 32'(chg_pulse), 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule